// File: doc/BRIEF.md
# Host Slave Bus Buffer Interface

This block is the slave end of a byte-wide link between a host processor and a local controller. The host reaches it with a chip select, a register-select line, and active-low read and write strobes on an 8-bit data bus. A host write fills an input buffer, and the level of the select line at that moment tags the byte as command or data. A host read returns either the output buffer or a status byte. The status byte carries an input-full flag, an output-full flag, the command tag, a local flag and a four-bit user field. The local controller drains the input buffer, fills the output buffer, writes the user field and writes the local flag through single-cycle strobes.

The four upper port bits pass through the block. After an enable strobe, two of them can carry buffer-state interrupt levels to the host. After another enable strobe, the other two carry a DMA request and acknowledge handshake. While the host holds a read of the status byte, the block defers every local change to that byte. It applies the deferred changes in the cycle the read ends, so the host never sees a byte that changes under its strobe.

Top module: `hsb_iface`

## Requirements
- R1: After reset the status byte is 0x00, `host_oe` is low, DMA and flag modes are off, and `port_pins` reads 4'b1111 because the port latch resets to all ones.
- R2: A host write with `cs_n` low captures `host_din` into the input buffer. In the cycle after the write strobe rises, status bit 1 (input full) becomes 1 and status bit 3 (command tag) takes the value of `a0`. While the strobe is still low, neither bit changes.
- R3: A host read with `a0`=0 presents the output buffer on `host_dout` with `host_oe` high, one cycle after the strobe is first seen low. Status bit 0 (output full) clears in the cycle after the strobe rises, and `host_oe` drops at the same point.
- R4: A host read with `a0`=1 presents the status byte on `host_dout` and leaves every status bit unchanged.
- R5: A local status write loads `loc_usr_d` into status bits 7..4 and leaves bits 3..0 unchanged.
- R6: A local input-buffer read clears status bit 1, and a local output-buffer load sets status bit 0, each one cycle later. If a host write ends in the same cycle as a local read, input full stays set. If a host data read ends in the same cycle as a local load, output full stays set and the new byte is held.
- R7: While a host status read is in progress, local user-field writes, flag writes, output-full sets and input-full clears leave the status byte unchanged. The most recent deferred values take effect in the cycle after the read strobe rises.
- R8: With `cs_n` high and no acknowledge active, host strobes change neither the input buffer nor any status bit, and `host_oe` stays low.
- R9: Once flag mode is enabled, `port_pins[0]` is latch bit 0 AND output full, and `port_pins[1]` is latch bit 1 AND NOT input full. Before that, both pins follow the latch.
- R10: Once DMA mode is enabled, a port write with `port_d[2]`=1 raises `port_pins[2]`, which is the request. A port write with `port_d[2]`=0 does not lower it. The request clears when a host read or write under acknowledge ends, and when DMA mode is enabled again.
- R11: In DMA mode, `port_pins[3]` is held at 1 and `dack_n` low selects the buffers without `cs_n`. Such accesses are data accesses: a read returns the output buffer even with `a0`=1, and a write clears the command tag.
- R12: A local flag write loads `loc_f0_d` into status bit 2 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| a0 | input | 1 | Host register select: 1 command/status, 0 data |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| host_din | input | DW | Host write data |
| host_dout | output | DW | Host read data (registered) |
| host_oe | output | 1 | Host bus drive enable |
| dack_n | input | 1 | DMA acknowledge, active low, used in DMA mode |
| loc_ibuf_rd | input | 1 | Local strobe: input buffer taken |
| loc_ibuf_q | output | DW | Input buffer contents |
| loc_obuf_ld | input | 1 | Local strobe: load output buffer |
| loc_obuf_d | input | DW | Output buffer load data |
| loc_sts_wr | input | 1 | Local strobe: write user status field |
| loc_usr_d | input | DW-4 | User status field value |
| loc_f0_wr | input | 1 | Local strobe: write local flag |
| loc_f0_d | input | 1 | Local flag value |
| loc_sts_q | output | DW | Current status byte |
| port_wr | input | 1 | Local strobe: write upper port latch |
| port_d | input | 4 | Upper port latch data (bit 0 = port bit 4) |
| flag_en | input | 1 | Local strobe: enable flag mode |
| dma_en | input | 1 | Local strobe: enable DMA mode, clears request |
| port_pins | output | 4 | Upper port pin levels after multiplexing |

## Verification
The bench builds the block with the default DW of 8, so one sweep covers every byte value through both buffers. Each write in that sweep also toggles the command tag. All sixteen user-field codes are written and read back against a known lower nibble. The flag pins are driven through all sixteen combinations of latch bits and buffer states. The narrow configuration also makes the cycle-exact corners cheap to place: deferral under a held status read, same-cycle host/local conflicts on both flags, and acknowledge-driven accesses with the select line set the wrong way.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  // status bit positions (host software decodes these)
  localparam int ST_OBF    = 0;
  localparam int ST_IBF    = 1;
  localparam int ST_F0     = 2;
  localparam int ST_F1     = 3;
  localparam int ST_USR_LO = 4;
  // upper port nibble: index 0 is port bit 4
  localparam int PORT_W    = 4;
  localparam int PIN_OBF   = 0;
  localparam int PIN_IBF   = 1;
  localparam int PIN_DRQ   = 2;
  localparam int PIN_DACK  = 3;
endpackage

// File: rtl/hsb_strobe.sv
// Tracks one active-low host strobe: captures select, tag and acknowledge
// while the strobe is low and reports the trailing edge.
module hsb_strobe (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  input  logic sel,
  input  logic tag,
  input  logic dk,
  output logic done,
  output logic tag_q,
  output logic dk_q
);
  logic low_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= 1'b0;
      sel_q <= 1'b0;
      tag_q <= 1'b0;
      dk_q  <= 1'b0;
    end else begin
      low_q <= ~strobe_n;
      if (!strobe_n) begin
        sel_q <= sel;
        tag_q <= tag;
        dk_q  <= dk;
      end
    end
  end

  assign done = strobe_n & low_q & sel_q;
endmodule

// File: rtl/hsb_status.sv
// Status byte with deferral of local updates during a host status read.
module hsb_status import hsb_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  logic          usr_wr,
  input  logic [DW-5:0] usr_d,
  input  logic          f0_wr,
  input  logic          f0_d,
  input  logic          obf_set,
  input  logic          ibf_clr,
  input  logic          wr_done,
  input  logic          wr_cmd,
  input  logic          rd_data_done,
  output logic [DW-1:0] sts
);
  localparam int UW = DW - ST_USR_LO;

  logic [UW-1:0] usr_q, pend_usr, usr_n;
  logic          f1_q, f0_q, ibf_q, obf_q;
  logic          pend_usr_v, pend_f0_v, pend_f0, pend_obf, pend_ibf;
  logic          usr_v, f0_v, f0_n, obf_s, ibf_c;

  always_comb begin
    usr_v = usr_wr | pend_usr_v;
    usr_n = usr_wr ? usr_d : pend_usr;
    f0_v  = f0_wr | pend_f0_v;
    f0_n  = f0_wr ? f0_d : pend_f0;
    obf_s = obf_set | pend_obf;
    ibf_c = ibf_clr | pend_ibf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usr_q      <= '0;
      pend_usr   <= '0;
      pend_usr_v <= 1'b0;
      pend_f0_v  <= 1'b0;
      pend_f0    <= 1'b0;
      pend_obf   <= 1'b0;
      pend_ibf   <= 1'b0;
      f1_q       <= 1'b0;
      f0_q       <= 1'b0;
      ibf_q      <= 1'b0;
      obf_q      <= 1'b0;
    end else begin
      if (lock) begin
        if (usr_wr) begin
          pend_usr_v <= 1'b1;
          pend_usr   <= usr_d;
        end
        if (f0_wr) begin
          pend_f0_v <= 1'b1;
          pend_f0   <= f0_d;
        end
        if (obf_set) pend_obf <= 1'b1;
        if (ibf_clr) pend_ibf <= 1'b1;
      end else begin
        pend_usr_v <= 1'b0;
        pend_f0_v  <= 1'b0;
        pend_obf   <= 1'b0;
        pend_ibf   <= 1'b0;
        if (usr_v) usr_q <= usr_n;
        if (f0_v)  f0_q  <= f0_n;
      end

      // host write wins over a local drain in the same cycle
      if (wr_done) begin
        ibf_q <= 1'b1;
        f1_q  <= wr_cmd;
      end else if (!lock && ibf_c) begin
        ibf_q <= 1'b0;
      end

      // a fresh local load wins over a host read ending together
      if (!lock && obf_s) obf_q <= 1'b1;
      else if (rd_data_done) obf_q <= 1'b0;
    end
  end

  always_comb begin
    sts                    = '0;
    sts[DW-1:ST_USR_LO]    = usr_q;
    sts[ST_F1]             = f1_q;
    sts[ST_F0]             = f0_q;
    sts[ST_IBF]            = ibf_q;
    sts[ST_OBF]            = obf_q;
  end
endmodule

// File: rtl/hsb_pinmux.sv
// Upper port latch with interrupt-flag and DMA handshake overlays.
module hsb_pinmux import hsb_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_d,
  input  logic              flag_en,
  input  logic              dma_en,
  input  logic              obf,
  input  logic              ibf,
  input  logic              dack_done,
  output logic              dma_on,
  output logic [PORT_W-1:0] pins
);
  logic [PORT_W-1:0] latch_q;
  logic              flag_q, dma_q, drq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      flag_q  <= 1'b0;
      dma_q   <= 1'b0;
      drq_q   <= 1'b0;
    end else begin
      if (port_wr) latch_q <= port_d;
      if (flag_en) flag_q <= 1'b1;
      if (dma_en)  dma_q  <= 1'b1;
      if (dma_en)
        drq_q <= 1'b0;
      else if (port_wr && port_d[PIN_DRQ] && dma_q)
        drq_q <= 1'b1;
      else if (dack_done)
        drq_q <= 1'b0;
    end
  end

  always_comb begin
    pins           = latch_q;
    pins[PIN_OBF]  = flag_q ? (latch_q[PIN_OBF] & obf)  : latch_q[PIN_OBF];
    pins[PIN_IBF]  = flag_q ? (latch_q[PIN_IBF] & ~ibf) : latch_q[PIN_IBF];
    pins[PIN_DRQ]  = dma_q  ? drq_q : latch_q[PIN_DRQ];
    pins[PIN_DACK] = dma_q  ? 1'b1  : latch_q[PIN_DACK];
  end

  assign dma_on = dma_q;
endmodule

// File: rtl/hsb_iface.sv
module hsb_iface import hsb_pkg::*; #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              a0,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DW-1:0]     host_din,
  output logic [DW-1:0]     host_dout,
  output logic              host_oe,
  input  logic              dack_n,
  input  logic              loc_ibuf_rd,
  output logic [DW-1:0]     loc_ibuf_q,
  input  logic              loc_obuf_ld,
  input  logic [DW-1:0]     loc_obuf_d,
  input  logic              loc_sts_wr,
  input  logic [DW-5:0]     loc_usr_d,
  input  logic              loc_f0_wr,
  input  logic              loc_f0_d,
  output logic [DW-1:0]     loc_sts_q,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_d,
  input  logic              flag_en,
  input  logic              dma_en,
  output logic [PORT_W-1:0] port_pins
);
  logic          dma_on, dack, sel, a0_eff, lock;
  logic          rd_done, rd_tag_q, rd_dk_q;
  logic          wr_done, wr_tag_q, wr_dk_q;
  logic          rd_data_done, dack_done;
  logic [DW-1:0] wr_dat_q, ibuf_q, obuf_q;

  assign dack   = dma_on & ~dack_n;
  assign sel    = ~cs_n | dack;
  assign a0_eff = a0 & ~dack;
  assign lock   = ~rd_n & sel & a0_eff;

  hsb_strobe u_rd (
    .clk(clk), .rst(rst), .strobe_n(rd_n), .sel(sel), .tag(a0_eff), .dk(dack),
    .done(rd_done), .tag_q(rd_tag_q), .dk_q(rd_dk_q)
  );

  hsb_strobe u_wr (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .sel(sel), .tag(a0_eff), .dk(dack),
    .done(wr_done), .tag_q(wr_tag_q), .dk_q(wr_dk_q)
  );

  assign rd_data_done = rd_done & ~rd_tag_q;
  assign dack_done    = (rd_done & rd_dk_q) | (wr_done & wr_dk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_dat_q  <= '0;
      ibuf_q    <= '0;
      obuf_q    <= '0;
      host_dout <= '0;
      host_oe   <= 1'b0;
    end else begin
      if (!wr_n)       wr_dat_q <= host_din;
      if (wr_done)     ibuf_q   <= wr_dat_q;
      if (loc_obuf_ld) obuf_q   <= loc_obuf_d;
      host_oe <= ~rd_n & sel;
      if (!rd_n && sel) host_dout <= a0_eff ? loc_sts_q : obuf_q;
    end
  end

  assign loc_ibuf_q = ibuf_q;

  hsb_status #(.DW(DW)) u_sts (
    .clk(clk), .rst(rst), .lock(lock),
    .usr_wr(loc_sts_wr), .usr_d(loc_usr_d),
    .f0_wr(loc_f0_wr), .f0_d(loc_f0_d),
    .obf_set(loc_obuf_ld), .ibf_clr(loc_ibuf_rd),
    .wr_done(wr_done), .wr_cmd(wr_tag_q), .rd_data_done(rd_data_done),
    .sts(loc_sts_q)
  );

  hsb_pinmux u_pins (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_d(port_d),
    .flag_en(flag_en), .dma_en(dma_en),
    .obf(loc_sts_q[ST_OBF]), .ibf(loc_sts_q[ST_IBF]),
    .dack_done(dack_done), .dma_on(dma_on), .pins(port_pins)
  );
endmodule

// File: rtl/hsb_iface_chk.sv
module hsb_iface_chk import hsb_pkg::*; #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_n,
  input logic          host_oe,
  input logic          wr_done,
  input logic          wr_cmd,
  input logic          rd_done,
  input logic          lock,
  input logic [DW-1:0] sts,
  input logic          dma_en,
  input logic          drq_pin
);
  p_ibf_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[ST_IBF]) |-> $past(wr_done));

  p_f1_tag_r2: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> (sts[ST_F1] == $past(wr_cmd)));

  p_obf_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sts[ST_OBF]) |-> $past(rd_done));

  p_oe_needs_read_r8: assert property (@(posedge clk) disable iff (rst)
    host_oe |-> $past(!rd_n));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(sts[DW-1:ST_USR_LO]) && $stable(sts[ST_F0]) && $stable(sts[ST_OBF])));

  p_drq_clear_r10: assert property (@(posedge clk) disable iff (rst)
    dma_en |=> !drq_pin);
endmodule

bind hsb_iface hsb_iface_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .host_oe(host_oe),
  .wr_done(wr_done), .wr_cmd(wr_tag_q), .rd_done(rd_done), .lock(lock),
  .sts(loc_sts_q), .dma_en(dma_en), .drq_pin(port_pins[2])
);

// File: tb/tb_hsb_iface.sv
module tb_hsb_iface;
  localparam int CLK_NS = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
  logic [DW-1:0] host_din = '0, host_dout, loc_ibuf_q, loc_obuf_d = '0, loc_sts_q;
  logic host_oe;
  logic loc_ibuf_rd = 1'b0, loc_obuf_ld = 1'b0, loc_sts_wr = 1'b0, loc_f0_wr = 1'b0, loc_f0_d = 1'b0;
  logic [3:0] loc_usr_d = '0;
  logic port_wr = 1'b0, flag_en = 1'b0, dma_en = 1'b0;
  logic [3:0] port_d = '0, port_pins;

  int total = 0;
  int bad = 0;
  logic [7:0] rdat;
  logic roe;

  always #(CLK_NS/2) clk = ~clk;

  hsb_iface #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe), .dack_n(dack_n),
    .loc_ibuf_rd(loc_ibuf_rd), .loc_ibuf_q(loc_ibuf_q),
    .loc_obuf_ld(loc_obuf_ld), .loc_obuf_d(loc_obuf_d),
    .loc_sts_wr(loc_sts_wr), .loc_usr_d(loc_usr_d),
    .loc_f0_wr(loc_f0_wr), .loc_f0_d(loc_f0_d), .loc_sts_q(loc_sts_q),
    .port_wr(port_wr), .port_d(port_d), .flag_en(flag_en), .dma_en(dma_en),
    .port_pins(port_pins)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic cs, input logic a, input logic [7:0] d);
    cs_n = cs; a0 = a; host_din = d; wr_n = 1'b0;
    tick();
    wr_n = 1'b1;
    tick();
    cs_n = 1'b1;
  endtask

  task automatic host_rd(input logic cs, input logic a, output logic [7:0] d, output logic oe);
    cs_n = cs; a0 = a; rd_n = 1'b0;
    tick();
    d = host_dout; oe = host_oe;
    rd_n = 1'b1;
    tick();
    cs_n = 1'b1;
  endtask

  task automatic ibuf_take();
    loc_ibuf_rd = 1'b1; tick(); loc_ibuf_rd = 1'b0;
  endtask

  task automatic obuf_load(input logic [7:0] d);
    loc_obuf_d = d; loc_obuf_ld = 1'b1; tick(); loc_obuf_ld = 1'b0;
  endtask

  task automatic port_write(input logic [3:0] d);
    port_d = d; port_wr = 1'b1; tick(); port_wr = 1'b0;
  endtask

  task automatic f0_write(input logic v);
    loc_f0_d = v; loc_f0_wr = 1'b1; tick(); loc_f0_wr = 1'b0;
  endtask

  task automatic usr_write(input logic [3:0] u);
    loc_usr_d = u; loc_sts_wr = 1'b1; tick(); loc_sts_wr = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 status", int'(loc_sts_q), 0);
    check("R1 host_oe", int'(host_oe), 0);
    check("R1 pins", int'(port_pins), 4'hF);

    // R2 flags only after trailing edge
    cs_n = 1'b0; a0 = 1'b1; host_din = 8'h5A; wr_n = 1'b0;
    tick();
    check("R2 ibf before edge", int'(loc_sts_q[1]), 0);
    check("R2 f1 before edge", int'(loc_sts_q[3]), 0);
    wr_n = 1'b1;
    tick();
    cs_n = 1'b1;
    check("R2 ibf after edge", int'(loc_sts_q[1]), 1);
    check("R2 f1 command", int'(loc_sts_q[3]), 1);
    check("R2 ibuf", int'(loc_ibuf_q), 8'h5A);
    ibuf_take();
    check("R6 ibf cleared", int'(loc_sts_q[1]), 0);

    // R2 sweep over all bytes, tag alternates with bit 0
    for (int v = 0; v < 256; v++) begin
      host_wr(1'b0, v[0], v[7:0]);
      check("R2 sweep ibuf", int'(loc_ibuf_q), v);
      check("R2 sweep f1/ibf", int'(loc_sts_q[3:0]), (v[0] ? 8 : 0) + 2);
      ibuf_take();
      check("R6 sweep ibf clear", int'(loc_sts_q[1]), 0);
    end

    // R3 sweep
    for (int v = 0; v < 256; v++) begin
      obuf_load(v[7:0]);
      check("R6 obf set", int'(loc_sts_q[0]), 1);
      host_rd(1'b0, 1'b0, rdat, roe);
      check("R3 data", int'(rdat), v);
      check("R3 oe", int'(roe), 1);
      check("R3 obf clear", int'(loc_sts_q[0]), 0);
      check("R3 oe drop", int'(host_oe), 0);
    end

    // R12 local flag; f1 is 1 from last sweep write
    f0_write(1'b1);
    check("R12 f0 set", int'(loc_sts_q[2]), 1);

    // R5 / R4 over all user codes; lower nibble 4'b1100
    for (int u = 0; u < 16; u++) begin
      usr_write(u[3:0]);
      check("R5 status", int'(loc_sts_q), u * 16 + 12);
      host_rd(1'b0, 1'b1, rdat, roe);
      check("R4 read status", int'(rdat), u * 16 + 12);
      check("R4 unchanged", int'(loc_sts_q), u * 16 + 12);
    end
    f0_write(1'b0);
    check("R12 f0 clear", int'(loc_sts_q[2]), 0);
    f0_write(1'b1);

    // R6 conflict: host write ends as local drains
    cs_n = 1'b0; a0 = 1'b0; host_din = 8'h3C; wr_n = 1'b0;
    tick();
    wr_n = 1'b1; loc_ibuf_rd = 1'b1;
    tick();
    loc_ibuf_rd = 1'b0; cs_n = 1'b1;
    check("R6 ibf host wins", int'(loc_sts_q[1]), 1);
    ibuf_take();
    // R6 conflict: host data read ends as local loads
    obuf_load(8'h11);
    cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0;
    tick();
    rd_n = 1'b1; loc_obuf_d = 8'h22; loc_obuf_ld = 1'b1;
    tick();
    loc_obuf_ld = 1'b0; cs_n = 1'b1;
    check("R6 obf local wins", int'(loc_sts_q[0]), 1);
    host_rd(1'b0, 1'b0, rdat, roe);
    check("R6 new byte", int'(rdat), 8'h22);

    // R7 lockout: status is usr 3, f1 0, f0 1, ibf 0, obf 0
    usr_write(4'h3);
    check("R7 pre status", int'(loc_sts_q), 8'h34);
    cs_n = 1'b0; a0 = 1'b1; rd_n = 1'b0;
    tick();
    loc_usr_d = 4'hC; loc_sts_wr = 1'b1; loc_obuf_d = 8'h77; loc_obuf_ld = 1'b1;
    loc_f0_d = 1'b0; loc_f0_wr = 1'b1;
    tick();
    loc_sts_wr = 1'b0; loc_obuf_ld = 1'b0; loc_f0_wr = 1'b0;
    tick();
    check("R7 held status", int'(loc_sts_q), 8'h34);
    check("R7 host sees stable", int'(host_dout), 8'h34);
    loc_f0_d = 1'b1; loc_f0_wr = 1'b1;
    tick();
    loc_f0_wr = 1'b0;
    check("R7 still held", int'(loc_sts_q), 8'h34);
    rd_n = 1'b1;
    tick();
    cs_n = 1'b1;
    check("R7 applied", int'(loc_sts_q), 8'hC5);

    // R8 unselected strobes
    host_wr(1'b1, 1'b0, 8'h99);
    check("R8 ibf", int'(loc_sts_q[1]), 0);
    check("R8 ibuf", int'(loc_ibuf_q), 8'h3C);
    cs_n = 1'b1; a0 = 1'b0; rd_n = 1'b0;
    tick();
    check("R8 oe", int'(host_oe), 0);
    rd_n = 1'b1;
    tick();
    check("R8 obf kept", int'(loc_sts_q[0]), 1);

    // R9 pins follow latch before flag mode
    host_rd(1'b0, 1'b0, rdat, roe);
    host_wr(1'b0, 1'b0, 8'h01);
    port_write(4'b0011);
    check("R9 before enable", int'(port_pins), 4'b0011);
    flag_en = 1'b1; tick(); flag_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k[2]) obuf_load(8'hA5); else host_rd(1'b0, 1'b0, rdat, roe);
      if (k[3]) host_wr(1'b0, 1'b0, 8'h5A); else ibuf_take();
      port_write({2'b10, k[1], k[0]});
      check("R9 flag pins", int'(port_pins),
            8 + (k[1] & ~k[3]) * 2 + (k[0] & k[2]));
    end

    // R10 / R11 DMA
    port_write(4'b0100);
    check("R10 latch before dma", int'(port_pins[3:2]), 2'b01);
    dma_en = 1'b1; tick(); dma_en = 1'b0;
    check("R10 drq low on enable", int'(port_pins[2]), 0);
    check("R11 ack pin released", int'(port_pins[3]), 1);
    port_write(4'b0100);
    check("R10 drq raised", int'(port_pins[2]), 1);
    port_write(4'b0000);
    check("R10 zero keeps drq", int'(port_pins[2]), 1);
    obuf_load(8'h5C);
    dack_n = 1'b0; cs_n = 1'b1; a0 = 1'b1; rd_n = 1'b0;
    tick();
    check("R11 dack oe", int'(host_oe), 1);
    check("R11 dack data", int'(host_dout), 8'h5C);
    rd_n = 1'b1;
    tick();
    check("R10 drq cleared by read", int'(port_pins[2]), 0);
    check("R11 obf cleared", int'(loc_sts_q[0]), 0);
    port_write(4'b0100);
    host_wr(1'b1, 1'b1, 8'h6D);
    check("R11 dack write ibuf", int'(loc_ibuf_q), 8'h6D);
    check("R11 dack write tag", int'(loc_sts_q[3]), 0);
    check("R10 drq cleared by write", int'(port_pins[2]), 0);
    dack_n = 1'b1;
    port_write(4'b0100);
    check("R10 drq again", int'(port_pins[2]), 1);
    dma_en = 1'b1; tick(); dma_en = 1'b0;
    check("R10 drq cleared by enable", int'(port_pins[2]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule